// File: doc/BRIEF.md
# PTP System Time Generator

This block keeps the seconds and sub-seconds system time that an IEEE 1588 timestamping unit stamps frames with. While running, the sub-second count grows by a programmed increment. In coarse mode this happens on every clock. In fine mode it happens only when a 32-bit accumulator, fed with a programmed addend on every clock, carries out. Trimming the addend lets the time track a reference frequency in very small steps.

Software programs the block through a single-cycle register write port. A command can overwrite the time, move the time forward or back by an offset, or copy a staged addend into the live accumulator path. Each command bit clears itself once the action has happened. The sub-second field wraps either at a binary limit or at one second expressed in nanoseconds. An armed alarm raises a one-cycle interrupt once the time passes a programmed target.

Top module: `ptp_sys_time`

## Requirements
- R1: After reset, seconds, sub-seconds, the control readback and the interrupt are all zero.
- R2: While the run bit (control bit 0, address 0) is clear, and no initialize or offset command is pending, the time does not change.
- R3: With run set and the fine bit (control bit 1) clear, the sub-seconds grow by the increment (address 1, low INC_W bits) on every clock.
- R4: With run and fine set, the live addend is added into a 32-bit accumulator on every clock, and the increment is applied only on clocks where that sum carries out of bit 31.
- R5: With the decimal bit (control bit 6) clear, a sub-second value above 0x7FFF_FFFF wraps by subtracting 0x8000_0000 and adds one to the seconds.
- R6: With the decimal bit set, a sub-second value above 999,999,999 wraps by subtracting 1,000,000,000 and adds one to the seconds.
- R7: Writing control bit 2 loads the time from the update seconds (address 3) and update sub-seconds (address 4) on the next clock, and that bit reads back zero afterwards.
- R8: Control bit 3 applies an offset on the next clock, then reads back zero. If bit 31 of the update sub-seconds is 0 it adds the update value; if 1 it subtracts it, using bits 30:0 as the magnitude. The sub-seconds carry or borrow one second at the active rollover limit.
- R9: When bits 2 and 3 are set by the same write, only the load happens, and both bits read back zero afterwards.
- R10: A write to the staged addend (address 2) does not change the fine rate until control bit 5 copies it into the live addend; bit 5 then reads back zero.
- R11: With the alarm bit (control bit 4) set, the interrupt pulses for one clock once the time is strictly later than the target seconds (address 5) and sub-seconds (address 6). The alarm bit then clears, and no pulse occurs while the alarm bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| sys_sec | output | 32 | Current seconds |
| sys_sub | output | 32 | Current sub-seconds |
| ctrl_rd | output | 7 | Control register readback, including the self-clearing command bits |
| tgt_irq | output | 1 | One-clock target-time interrupt |

## Verification
The assertions check the following on every cycle:
- the time freezes when the block is idle;
- a coarse step adds exactly the increment when no wrap occurs;
- a load, including one that coincides with an offset command, takes the update values;
- a command bit clears after acting unless it is rewritten;
- the interrupt cannot repeat while the alarm is disarmed.

Other behaviours depend on long stimulus histories, and only the bench scenarios can show them:
- fine-mode cadence under different addends;
- that a staged addend stays inert until it is loaded;
- the borrow on a subtracted offset and the carry on an added one, in both rollover modes;
- the alarm staying silent when unarmed.

// File: rtl/ptp_sys_time.sv
module ptp_sys_time #(
  parameter int INC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] sys_sec,
  output logic [31:0] sys_sub,
  output logic [6:0]  ctrl_rd,
  output logic        tgt_irq
);

  localparam logic [32:0] BIN_WRAP = 33'h0_8000_0000;
  localparam logic [32:0] DEC_WRAP = 33'd1_000_000_000;

  logic [6:0]       ctrl;
  logic [INC_W-1:0] inc;
  logic [31:0]      addend_sh, addend, acc;
  logic [31:0]      upd_sec, upd_sub, tgt_sec, tgt_sub;

  wire run      = ctrl[0];
  wire fine     = ctrl[1];
  wire do_init  = ctrl[2];
  wire do_adj   = ctrl[3];
  wire armed    = ctrl[4];
  wire do_load  = ctrl[5];
  wire dec      = ctrl[6];
  wire ctrl_wr  = wr_en && wr_addr == 3'd0;

  wire [32:0] wrap    = dec ? DEC_WRAP : BIN_WRAP;
  wire [32:0] acc_sum = {1'b0, acc} + {1'b0, addend};
  wire        step    = run && (fine ? acc_sum[32] : 1'b1);

  wire [32:0] sub_inc  = {1'b0, sys_sub} + 33'(inc);
  wire        inc_wrap = sub_inc >= wrap;

  wire [32:0] adj_mag  = {2'b00, upd_sub[30:0]};
  wire [32:0] sub_add  = {1'b0, sys_sub} + adj_mag;
  wire        add_wrap = sub_add >= wrap;
  wire        borrow   = {1'b0, sys_sub} < adj_mag;
  wire [32:0] sub_sub  = {1'b0, sys_sub} - adj_mag + (borrow ? wrap : 33'd0);

  wire late = (sys_sec > tgt_sec) || (sys_sec == tgt_sec && sys_sub > tgt_sub);

  assign ctrl_rd = ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      inc       <= '0;
      addend_sh <= '0;
      addend    <= '0;
      acc       <= '0;
      upd_sec   <= '0;
      upd_sub   <= '0;
      tgt_sec   <= '0;
      tgt_sub   <= '0;
      sys_sec   <= '0;
      sys_sub   <= '0;
      tgt_irq   <= 1'b0;
    end else begin
      tgt_irq <= armed && late;

      if (run && fine) acc <= acc_sum[31:0];
      if (do_load) addend <= addend_sh;

      if (do_init) begin
        sys_sec <= upd_sec;
        sys_sub <= upd_sub;
      end else if (do_adj) begin
        if (upd_sub[31]) begin
          sys_sec <= sys_sec - upd_sec - 32'(borrow);
          sys_sub <= sub_sub[31:0];
        end else begin
          sys_sec <= sys_sec + upd_sec + 32'(add_wrap);
          sys_sub <= add_wrap ? 32'(sub_add - wrap) : sub_add[31:0];
        end
      end else if (step) begin
        sys_sec <= sys_sec + 32'(inc_wrap);
        sys_sub <= inc_wrap ? 32'(sub_inc - wrap) : sub_inc[31:0];
      end

      if (ctrl_wr) begin
        ctrl <= wr_data[6:0];
      end else begin
        ctrl[2] <= 1'b0;
        ctrl[3] <= 1'b0;
        ctrl[5] <= 1'b0;
        if (armed && late) ctrl[4] <= 1'b0;
      end

      if (wr_en) begin
        case (wr_addr)
          3'd1: inc       <= wr_data[INC_W-1:0];
          3'd2: addend_sh <= wr_data;
          3'd3: upd_sec   <= wr_data;
          3'd4: upd_sub   <= wr_data;
          3'd5: tgt_sec   <= wr_data;
          3'd6: tgt_sub   <= wr_data;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ptp_sys_time_chk.sv
module ptp_sys_time_chk #(
  parameter int INC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [31:0]      sys_sec,
  input logic [31:0]      sys_sub,
  input logic [6:0]       ctrl_rd,
  input logic             tgt_irq,
  input logic [INC_W-1:0] inc,
  input logic [31:0]      upd_sec,
  input logic [31:0]      upd_sub
);

  wire ctrl_wr = wr_en && wr_addr == 3'd0;

  // R2
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[0] && !ctrl_rd[2] && !ctrl_rd[3] |=> $stable(sys_sec) && $stable(sys_sub));

  // R3
  a_r3_coarse_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[0] && !ctrl_rd[1] && !ctrl_rd[2] && !ctrl_rd[3] && !ctrl_rd[6]
      && ({1'b0, sys_sub} + 33'(inc) < 33'h0_8000_0000)
    |=> sys_sub == $past(sys_sub) + 32'($past(inc)) && $stable(sys_sec));

  // R7 and R9
  a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[2] |=> sys_sec == $past(upd_sec) && sys_sub == $past(upd_sub));

  a_r7_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[2] && !ctrl_wr |=> !ctrl_rd[2]);

  // R8
  a_r8_adj_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[3] && !ctrl_wr |=> !ctrl_rd[3]);

  // R9
  a_r9_both_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[2] && ctrl_rd[3] && !ctrl_wr |=> !ctrl_rd[2] && !ctrl_rd[3]);

  // R10
  a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[5] && !ctrl_wr |=> !ctrl_rd[5]);

  // R11
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_irq && !ctrl_rd[4] |=> !tgt_irq);

  a_r11_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_irq) && !$past(ctrl_wr) |-> !ctrl_rd[4]);

endmodule

bind ptp_sys_time ptp_sys_time_chk #(.INC_W(INC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sys_sec(sys_sec), .sys_sub(sys_sub), .ctrl_rd(ctrl_rd), .tgt_irq(tgt_irq),
  .inc(inc), .upd_sec(upd_sec), .upd_sub(upd_sub)
);

// File: tb/tb_ptp_sys_time.sv
module tb_ptp_sys_time;
  localparam int CLK_PERIOD = 10;
  localparam longint M32 = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sys_sec, sys_sub;
  logic [6:0]  ctrl_rd;
  logic        tgt_irq;

  ptp_sys_time dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_sec(sys_sec), .sys_sub(sys_sub), .ctrl_rd(ctrl_rd), .tgt_irq(tgt_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, irq_count = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference model
  longint m_ctrl, m_inc, m_ash, m_add, m_acc, m_usec, m_usub, m_tsec, m_tsub;
  longint m_sec, m_sub;
  bit m_irq;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_inc = 0; m_ash = 0; m_add = 0; m_acc = 0;
      m_usec = 0; m_usub = 0; m_tsec = 0; m_tsub = 0;
      m_sec = 0; m_sub = 0; m_irq = 0;
    end else begin
      longint wrapv, mag, sum;
      bit late, armed, stepit;
      wrapv = m_ctrl[6] ? 64'd1000000000 : 64'h8000_0000;
      late = (m_sec > m_tsec) || (m_sec == m_tsec && m_sub > m_tsub);
      armed = m_ctrl[4];
      m_irq = armed && late;
      sum = m_acc + m_add;
      stepit = m_ctrl[0] && (!m_ctrl[1] || sum > M32);
      if (m_ctrl[2]) begin
        m_sec = m_usec; m_sub = m_usub;
      end else if (m_ctrl[3]) begin
        mag = m_usub & 64'h7FFF_FFFF;
        if (m_usub[31]) begin
          if (m_sub >= mag) begin m_sub = m_sub - mag; m_sec = m_sec - m_usec; end
          else begin m_sub = m_sub + wrapv - mag; m_sec = m_sec - m_usec - 1; end
        end else begin
          m_sub = m_sub + mag; m_sec = m_sec + m_usec;
          if (m_sub >= wrapv) begin m_sub = m_sub - wrapv; m_sec = m_sec + 1; end
        end
      end else if (stepit) begin
        m_sub = m_sub + m_inc;
        if (m_sub >= wrapv) begin m_sub = m_sub - wrapv; m_sec = m_sec + 1; end
      end
      m_sec = m_sec & M32;
      m_sub = m_sub & M32;
      if (m_ctrl[0] && m_ctrl[1]) m_acc = sum & M32;
      if (m_ctrl[5]) m_add = m_ash;
      if (wr_en && wr_addr == 0) m_ctrl = longint'(wr_data) & 64'h7F;
      else begin
        m_ctrl = m_ctrl & ~64'h2C;
        if (armed && late) m_ctrl = m_ctrl & ~64'h10;
      end
      if (wr_en) case (wr_addr)
        3'd1: m_inc  = longint'(wr_data) & 64'hFF;
        3'd2: m_ash  = longint'(wr_data);
        3'd3: m_usec = longint'(wr_data);
        3'd4: m_usub = longint'(wr_data);
        3'd5: m_tsec = longint'(wr_data);
        3'd6: m_tsub = longint'(wr_data);
        default: ;
      endcase
    end
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check({cur_req, " sec vs model"}, longint'(sys_sec), m_sec);
      check({cur_req, " sub vs model"}, longint'(sys_sub), m_sub);
      check({cur_req, " ctrl vs model"}, longint'(ctrl_rd), m_ctrl);
      check({cur_req, " irq vs model"}, longint'(tgt_irq), longint'(m_irq));
      if (tgt_irq) irq_count++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [31:0] s, input logic [31:0] ss, input logic [6:0] mode);
    wr(3'd3, s);
    wr(3'd4, ss);
    wr(3'd0, {25'd0, mode | 7'h04});
    idle(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    longint s0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 sec", sys_sec, 0);
    check("R1 sub", sys_sub, 0);
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 irq", tgt_irq, 0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R7";
    set_time(32'd10, 32'd100, 7'h00);
    check("R7 init sec", sys_sec, 10);
    check("R7 init sub", sys_sub, 100);
    check("R7 init bit cleared", ctrl_rd[2], 0);

    cur_req = "R2";
    wr(3'd1, 32'd7);
    s0 = sys_sub;
    idle(10);
    check("R2 held while stopped", sys_sub, s0);

    cur_req = "R3";
    wr(3'd0, 32'h01);
    s0 = sys_sub;
    idle(10);
    check("R3 coarse ten steps", sys_sub, s0 + 70);

    cur_req = "R5";
    wr(3'd0, 32'h00);
    set_time(32'd20, 32'h7FFF_FFFC, 7'h00);
    wr(3'd0, 32'h01);
    idle(1);
    check("R5 binary wrap sub", sys_sub, 3);
    check("R5 binary wrap sec", sys_sec, 21);

    cur_req = "R6";
    wr(3'd0, 32'h40);
    set_time(32'd30, 32'd999_999_995, 7'h40);
    wr(3'd0, 32'h41);
    idle(1);
    check("R6 decimal wrap sub", sys_sub, 2);
    check("R6 decimal wrap sec", sys_sec, 31);

    cur_req = "R4";
    wr(3'd0, 32'h00);
    wr(3'd2, 32'h8000_0000);
    wr(3'd0, 32'h22);
    idle(1);
    set_time(32'd0, 32'd0, 7'h02);
    wr(3'd0, 32'h03);
    s0 = sys_sub;
    idle(10);
    check("R4 fine half rate", sys_sub, s0 + 35);

    cur_req = "R10";
    wr(3'd2, 32'h4000_0000);
    s0 = sys_sub;
    idle(8);
    check("R10 staged addend inert", sys_sub, s0 + 28);
    wr(3'd0, 32'h23);
    idle(1);
    check("R10 load bit cleared", ctrl_rd[5], 0);
    s0 = sys_sub;
    idle(8);
    check("R10 quarter rate after load", sys_sub, s0 + 14);

    cur_req = "R8";
    wr(3'd0, 32'h00);
    set_time(32'd50, 32'd100, 7'h00);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'h7FFF_FFF0);
    wr(3'd0, 32'h08);
    idle(1);
    check("R8 add carry sub", sys_sub, 84);
    check("R8 add carry sec", sys_sec, 54);
    check("R8 adjust bit cleared", ctrl_rd[3], 0);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'h8000_00C8);
    wr(3'd0, 32'h08);
    idle(1);
    check("R8 sub borrow sub", sys_sub, 64'h7FFF_FF8C);
    check("R8 sub borrow sec", sys_sec, 52);
    set_time(32'd5, 32'd999_999_000, 7'h40);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd2000);
    wr(3'd0, 32'h48);
    idle(1);
    check("R8 decimal add sub", sys_sub, 1000);
    check("R8 decimal add sec", sys_sec, 6);
    wr(3'd4, 32'h8000_0BB8);
    wr(3'd0, 32'h48);
    idle(1);
    check("R8 decimal borrow sub", sys_sub, 999_998_000);
    check("R8 decimal borrow sec", sys_sec, 5);

    cur_req = "R9";
    wr(3'd3, 32'd77);
    wr(3'd4, 32'd7);
    wr(3'd0, 32'h0C);
    idle(1);
    check("R9 init wins sec", sys_sec, 77);
    check("R9 init wins sub", sys_sub, 7);
    check("R9 both bits cleared", ctrl_rd[3:2], 0);

    cur_req = "R11";
    wr(3'd0, 32'h00);
    set_time(32'd100, 32'd0, 7'h00);
    wr(3'd5, 32'd100);
    wr(3'd6, 32'd20);
    irq_count = 0;
    wr(3'd0, 32'h01);
    idle(10);
    check("R11 no pulse unarmed", irq_count, 0);
    wr(3'd0, 32'h00);
    set_time(32'd100, 32'd0, 7'h00);
    irq_count = 0;
    wr(3'd0, 32'h11);
    idle(10);
    check("R11 one pulse armed", irq_count, 1);
    check("R11 alarm bit cleared", ctrl_rd[4], 0);

    idle(2);
    finish_run();
  end
endmodule